// File: doc/BRIEF.md
# MDIO Management Bus Master

This block is a register-programmed master for the two-wire PHY management bus. It produces the management clock and drives or samples the shared data line through separate output, output-enable and input pins, so the pad and any pull-up sit outside. It handles both the older short-address frame format and the extended format with a separate address cycle. Software programs a divider and a frame format, loads the PHY and device addresses, and starts one frame at a time by writing a register. It then polls a busy flag until the frame is over.

Four 32-bit registers sit at byte offsets 0x0 (configuration and status), 0x4 (control), 0x8 (data) and 0xC (register address). Reads return the selected register combinationally. A write to the data register starts a write frame. A control write with bit 15 set starts a read frame. In extended mode, a write to the address register starts an address frame. Every frame is 32 preamble ones followed by start, opcode, PHY address, device address, turnaround and 16 data bits, sent most significant bit first.

Top module: `mdio_master`

## Requirements
- R1: After reset, all four registers read 0, so busy, error and extended mode are all clear. The clock output is low and the output enable is low.
- R2: Configuration fields read back as written: the divider field is in bits 15:8, extended mode in bit 6 and falling-edge launch in bit 23. Bits 1:0 are read-only status, and all other bits read 0. Control bits 9:5 hold the PHY address and bits 4:0 the device or register address.
- R3: While busy, the clock output has a period of 2*N system cycles with a 50% duty cycle, where N is the divider field (a field of 0 acts as 1). While idle, the clock output stays low.
- R4: In short mode, a data write sends 32 ones, start 01, opcode 01, the PHY address, the register address, turnaround 10 and the 16 written bits, all driven with the output enable high.
- R5: A read frame sends start and opcode (short mode 01 then 10), then both addresses. The output enable is released for the 2 turnaround and 16 data bit periods. The input is sampled on rising clock edges, and the 16 bits captured read back from the data register.
- R6: In extended mode, an address-register write sends start 00, opcode 00 and the written 16-bit address in the data field. In short mode, that write only stores the value and starts no frame.
- R7: In extended mode, the start code is 00, a data write uses opcode 01 and a read uses opcode 11.
- R8: Status bit 1 is set when the input is high at the second turnaround bit of a read. Starting the next frame clears it.
- R9: Status bit 0 is high from the start write until one clock period after the last data bit, so a frame lasts 65 clock periods with 65 rising edges.
- R10: With bit 23 clear, the data output changes only on rising clock edges. With bit 23 set, it changes only on falling edges.
- R11: Register writes are ignored while busy: nothing is stored and no further frame starts.
- R12: A control write with bit 15 clear stores the addresses and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the register at bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The hardest situation to reach is a read in which the PHY must drive the turnaround low and then present data at exactly the bit periods where the master has released the line. The bench models the PHY by counting falling clock edges, so it always knows which bit period is current. It drives its pattern only in that window, or leaves the line pulled high to mimic an absent PHY. This is repeated across every divider from 0 to 3, both launch edges and both frame formats. Writes are also issued in the middle of a frame, to show that they leave no trace once busy clears.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRAME = PRE + 32;
  localparam int TA_BIT = PRE + 14;
  localparam int CW = $clog2(FRAME + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME);
  localparam logic [CW-1:0] TA_I = CW'(TA_BIT);
  localparam logic [CW-1:0] TA2_I = CW'(TA_BIT + 1);
  localparam logic [CW-1:0] DAT_I = CW'(TA_BIT + 2);

  logic [7:0]       div_q, hcnt_q;
  logic             c45_q, neg_q, busy_q, err_q, rd_q, drv_q;
  logic [4:0]       dev_q, port_q;
  logic [15:0]      data_q, addr_q;
  logic [FRAME-1:0] frm_q;
  logic [CW-1:0]    bitn_q;

  wire idle_wr = bus_wr && !busy_q;
  wire wr_cfg  = idle_wr && bus_addr == 4'h0;
  wire wr_ctl  = idle_wr && bus_addr == 4'h4;
  wire wr_dat  = idle_wr && bus_addr == 4'h8;
  wire wr_adr  = idle_wr && bus_addr == 4'hC;
  wire go_rd   = wr_ctl && bus_wdata[15];
  wire go_ad   = wr_adr && c45_q;
  wire start   = go_rd || wr_dat || go_ad;

  logic [1:0]  op_c;
  logic [4:0]  port_n, dev_n;
  logic [15:0] fdata_n;

  always_comb begin
    port_n  = go_rd ? bus_wdata[9:5] : port_q;
    dev_n   = go_rd ? bus_wdata[4:0] : dev_q;
    fdata_n = go_rd ? 16'hFFFF : bus_wdata[15:0];
    if (go_ad)      op_c = 2'b00;
    else if (go_rd) op_c = c45_q ? 2'b11 : 2'b10;
    else            op_c = 2'b01;
  end

  wire [7:0]    half   = (div_q == 8'd0) ? 8'd1 : div_q;
  wire          tick   = busy_q && hcnt_q == half - 8'd1;
  wire          rise   = tick && !mdc;
  wire          fall   = tick && mdc;
  wire          launch = neg_q ? fall : rise;
  wire [CW-1:0] nxt    = bitn_q + CW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;  c45_q  <= 1'b0; neg_q <= 1'b0;
      dev_q  <= '0;  port_q <= '0;   data_q <= '0; addr_q <= '0;
      busy_q <= 1'b0; err_q <= 1'b0; rd_q <= 1'b0; drv_q <= 1'b0;
      frm_q  <= '0;  bitn_q <= '0;   hcnt_q <= '0; mdc <= 1'b0;
    end else begin
      if (wr_cfg) begin
        div_q <= bus_wdata[15:8];
        c45_q <= bus_wdata[6];
        neg_q <= bus_wdata[23];
      end
      if (wr_ctl) begin
        dev_q  <= bus_wdata[4:0];
        port_q <= bus_wdata[9:5];
      end
      if (wr_adr) addr_q <= bus_wdata[15:0];
      if (wr_dat) data_q <= bus_wdata[15:0];
      if (start) begin
        busy_q <= 1'b1;
        rd_q   <= go_rd;
        err_q  <= 1'b0;
        drv_q  <= 1'b1;
        frm_q  <= {{PRE{1'b1}}, c45_q ? 2'b00 : 2'b01, op_c, port_n, dev_n, 2'b10, fdata_n};
        bitn_q <= '0;
        hcnt_q <= '0;
        mdc    <= 1'b0;
      end else if (busy_q) begin
        hcnt_q <= tick ? 8'd0 : hcnt_q + 8'd1;
        if (tick) mdc <= ~mdc;
        if (launch) begin
          frm_q <= frm_q << 1;
          drv_q <= (nxt < LAST) && !(rd_q && nxt >= TA_I);
        end
        if (rise && rd_q) begin
          if (bitn_q == TA2_I && mdio_i) err_q <= 1'b1;
          if (bitn_q >= DAT_I && bitn_q < LAST) data_q <= {data_q[14:0], mdio_i};
        end
        if (fall) begin
          bitn_q <= nxt;
          if (bitn_q == LAST) busy_q <= 1'b0;
        end
      end
    end
  end

  assign mdio_o  = frm_q[FRAME-1];
  assign mdio_oe = busy_q && drv_q;

  always_comb begin
    case (bus_addr)
      4'h0:    bus_rdata = {8'd0, neg_q, 7'd0, div_q, 1'b0, c45_q, 4'd0, err_q, busy_q};
      4'h4:    bus_rdata = {22'd0, port_q, dev_q};
      4'h8:    bus_rdata = {16'd0, data_q};
      4'hC:    bus_rdata = {16'd0, addr_q};
      default: bus_rdata = '0;
    endcase
  end

  logic unused_wbits;
  assign unused_wbits = ^{bus_wdata[31:24], bus_wdata[22:16]};

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (!mdc && !mdio_oe));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> ($stable(div_q) && $stable(c45_q) && $stable(neg_q)));

  assert_release_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && !mdio_oe) |=> !mdio_oe);

  assert_launch_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && mdio_o != $past(mdio_o)) |-> (mdc != $past(mdc) && mdc == !neg_q));

  assert_err_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> (busy_q && rd_q));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> (!mdc && $past(mdc)));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  bus_addr = 4'h0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  mdio_master uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int errs = 0, checks = 0;
  int rises = 0, falls = 0, hicnt = 0, busycnt = 0, badlaunch = 0;
  logic [63:0] fb = '0, fo = '0;
  logic lm = 0, lo = 0, loe = 0, lbusy = 0;
  logic neg_exp = 0, rd_exp = 0, phy_on = 0, cur_c45 = 0;
  logic [15:0] phy_val = '0;
  int ed = 1;

  wire busy_now = (bus_addr == 4'h0) ? bus_rdata[0] : lbusy;

  always @(negedge clk) begin
    if (mdc && !lm) begin
      rises++;
      if (rises <= 64) begin
        fb[64-rises] = lo;
        fo[64-rises] = loe;
      end
    end
    if (!mdc && lm) falls++;
    if (mdc) hicnt++;
    if (busy_now) busycnt++;
    if (busy_now && lbusy && mdio_o != lo && !(mdc != lm && mdc == !neg_exp)) badlaunch++;
    lm = mdc; lo = mdio_o; loe = mdio_oe; lbusy = busy_now;
  end

  always_comb begin
    if (phy_on && rd_exp && falls == 47) mdio_i = 1'b0;
    else if (phy_on && rd_exp && falls >= 48 && falls < 64) mdio_i = phy_val[15-(falls-48)];
    else mdio_i = 1'b1;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; #1;
    d = bus_rdata;
    bus_addr = 4'h0;
  endtask

  task automatic clear_mon();
    @(negedge clk); #1;
    rises = 0; falls = 0; hicnt = 0; busycnt = 0; badlaunch = 0; fb = '0; fo = '0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk); #1;
    while (bus_rdata[0] && n < 5000) begin
      @(negedge clk); #1;
      n++;
    end
    if (n >= 5000) chk("R9", "busy timeout", 1, 0);
  endtask

  task automatic set_cfg(input int dv, input logic c45, input logic ng);
    wr(4'h0, {8'd0, ng, 7'd0, 8'(dv), 1'b0, c45, 6'd0});
    neg_exp = ng; cur_c45 = c45; ed = (dv == 0) ? 1 : dv;
  endtask

  // kind: 0 address frame, 1 write frame, 2 read frame
  task automatic frame(input int kind, input logic [4:0] p, input logic [4:0] d,
                       input logic [15:0] v, input logic on);
    logic [63:0] exp, msk;
    logic [1:0]  op;
    logic [31:0] r;
    string rq;
    rd_exp = (kind == 2); phy_on = on; phy_val = v;
    if (kind != 2) wr(4'h4, {22'd0, p, d});
    clear_mon();
    case (kind)
      0: wr(4'hC, {16'd0, v});
      1: wr(4'h8, {16'd0, v});
      default: wr(4'h4, {16'd0, 1'b1, 5'd0, p, d});
    endcase
    wait_idle();
    op  = (kind == 0) ? 2'b00 : (kind == 1) ? 2'b01 : (cur_c45 ? 2'b11 : 2'b10);
    exp = {32'hFFFF_FFFF, cur_c45 ? 2'b00 : 2'b01, op, p, d, 2'b10, v};
    msk = (kind == 2) ? {{46{1'b1}}, 18'd0} : '1;
    rq  = (kind == 0) ? "R6" : cur_c45 ? "R7" : (kind == 1) ? "R4" : "R5";
    chk(rq, "frame bits", fb & msk, exp & msk);
    chk(rq, "drive enable", fo, msk);
    chk("R9", "busy cycles", busycnt, 130 * ed);
    chk("R9", "clock rises", rises, 65);
    chk("R3", "clock high cycles", hicnt, 65 * ed);
    chk("R10", "launch edge violations", badlaunch, 0);
    if (kind == 2) begin
      rd(4'h8, r);
      chk("R5", "read data", r, {16'd0, on ? v : 16'hFFFF});
      rd(4'h0, r);
      chk("R8", "read error flag", r[1], !on);
    end else begin
      rd(4'h0, r);
      chk("R8", "error cleared", r[1], 1'b0);
    end
    rd_exp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL R9 watchdog expired: actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "clock after reset", mdc, 0);
    chk("R1", "enable after reset", mdio_oe, 0);
    rd(4'h0, r); chk("R1", "config after reset", r, 0);
    rd(4'h4, r); chk("R1", "control after reset", r, 0);
    rd(4'h8, r); chk("R1", "data after reset", r, 0);
    rd(4'hC, r); chk("R1", "address after reset", r, 0);

    wr(4'h0, 32'hFF80_81C3);
    rd(4'h0, r); chk("R2", "config readback", r, 32'h0080_8140);
    wr(4'h4, 32'h0000_7E3A);
    rd(4'h4, r); chk("R2", "control readback", r, 32'h0000_023A);

    set_cfg(1, 1'b0, 1'b0);
    clear_mon();
    wr(4'h4, 32'h0000_03FF);
    repeat (20) @(negedge clk);
    #1 rd(4'h0, r);
    chk("R12", "no frame from plain control write", {r[0], 8'(rises)}, 0);
    rd(4'h4, r); chk("R12", "control stored", r, 32'h0000_03FF);

    clear_mon();
    wr(4'hC, 32'h0000_0ABC);
    repeat (20) @(negedge clk);
    #1 rd(4'h0, r);
    chk("R6", "short mode address write starts nothing", {r[0], 8'(rises)}, 0);
    rd(4'hC, r); chk("R6", "address stored", r, 32'h0000_0ABC);

    for (int dv = 0; dv < 4; dv++)
      for (int ng = 0; ng < 2; ng++)
        for (int m = 0; m < 2; m++) begin
          logic [4:0] p, d;
          logic [15:0] v;
          p = 5'(dv * 7 + ng * 3 + m + 1);
          d = 5'(31 - dv * 5 - m * 2);
          v = 16'hA5C3 ^ 16'(dv * 16'h1111) ^ 16'(ng * 16'h0F0F) ^ 16'(m * 16'h8001);
          set_cfg(dv, m[0], ng[0]);
          if (m == 1) frame(0, p, d, ~v, 1'b0);
          frame(1, p, d, v, 1'b0);
          frame(2, p, d, v ^ 16'h3C3C, 1'b1);
          frame(2, p, d, 16'h0000, 1'b0);
        end

    set_cfg(0, 1'b0, 1'b0);
    wr(4'hC, 32'h0000_0ABC);
    set_cfg(2, 1'b0, 1'b0);
    wr(4'h4, {22'd0, 5'd3, 5'd4});
    clear_mon();
    wr(4'h8, 32'h0000_1234);
    wr(4'h0, 32'h0080_0540);
    wr(4'h4, 32'h0000_8000);
    wr(4'h8, 32'h0000_BEEF);
    wr(4'hC, 32'h0000_7777);
    wait_idle();
    chk("R11", "frame unaffected", fb, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd3, 5'd4, 2'b10, 16'h1234});
    rd(4'h0, r); chk("R11", "config unchanged", r, 32'h0000_0200);
    rd(4'h4, r); chk("R11", "control unchanged", r, {22'd0, 5'd3, 5'd4});
    rd(4'h8, r); chk("R11", "data unchanged", r, 32'h0000_1234);
    rd(4'hC, r); chk("R11", "address unchanged", r, 32'h0000_0ABC);
    repeat (20) @(negedge clk);
    #1 rd(4'h0, r);
    chk("R11", "no queued frame", r[0], 1'b0);
    summary();
  end
endmodule